// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching up to two entries from memory. The upper ten address bits select an entry in a 4 KB page directory, located through a base-frame input; that entry names a page table, whose entry (selected by the middle ten bits) supplies the physical frame for the low twelve offset bits. When the large-page enable is high and the directory entry carries its page-size flag, the directory entry maps a 4 MB region directly and the table fetch is skipped.

On the way it enforces present, write and user permissions and reports any fault with a cause code and the level at which the walk stopped. A successful walk writes back the accessed flag into every entry that lacked it, and the dirty flag into the final entry on a write, before the response is raised. One walk runs at a time: a valid/ready request port accepts an address, a write flag and a user flag, and a one-cycle response pulse returns the result. Memory is reached through a single word port with request and acknowledge.

Top module: `pgwalk_top`

## Requirements
- R1: `req_ready` is high only when no walk is in flight; after a request is accepted it stays low until the cycle after the one-cycle `rsp_valid` pulse.
- R2: The first read of every walk is at address {`ptbase_frame`, va[31:22], 2'b00}.
- R3: For a 4 KB mapping the second read is at {directory entry[31:12], va[21:12], 2'b00}, and `rsp_pa` is {table entry[31:12], va[11:0]}.
- R4: With `large_pg_en` high and bit 7 of the directory entry set, `rsp_pa` is {directory entry[31:22], va[21:0]} and only one read is made.
- R5: With `large_pg_en` low, bit 7 of the directory entry has no effect and the walk reads the page table.
- R6: Bit 0 clear in the directory entry gives `rsp_code` 1 with `rsp_level` 0; bit 0 clear in the table entry gives `rsp_code` 1 with `rsp_level` 1; a faulting walk writes nothing to memory.
- R7: A user access (`req_user` high) where bit 2 is clear in either entry gives `rsp_code` 3; this takes priority over a write-protection fault.
- R8: A write access where bit 1 is clear in either entry gives `rsp_code` 2.
- R9: On success each entry lacking bit 5 is written back with bit 5 set, the directory entry before the table entry; entries already carrying it are not written for that reason.
- R10: On a successful write access bit 6 is set in the final entry (table entry, or directory entry for a large page) and never in a directory entry that points to a table.
- R11: Bits 9 to 11 of an entry do not change the result and are kept unchanged in any write-back.
- R12: `rsp_fault` is high exactly when `rsp_code` is non-zero, and `rsp_pa` is zero on a fault; levels are 0 for directory and 1 for page table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbase_frame | input | 20 | Frame number of the page directory, held stable during a walk |
| large_pg_en | input | 1 | Allows 4 MB mappings from directory entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 32 | Virtual address to translate |
| req_wr | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_code | output | 2 | 0 none, 1 not present, 2 write protection, 3 user protection |
| rsp_level | output | 1 | Level where the fault was found (0 directory, 1 table) |
| rsp_pa | output | 32 | Translated physical address, zero on fault |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory access completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
Walks are driven through small page tables built in a bench memory: a first 4 KB read with both accessed flags clear, a repeat with them set, and a write that must add only the dirty flag, which together separate the write-back paths. Permission faults are provoked with the denying bit placed in the directory entry in one case and in the table entry in another, proving the two are combined, plus a user write to a read-only supervisor page that exposes the fault priority. The same directory entry with its size flag set is walked with large pages enabled and disabled, which distinguishes the one-read shortcut from the two-level path, and missing entries at each level check the reported level and the absence of writes.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

   // Entry flag positions: decoded by the walker itself
   localparam int unsigned ENT_P  = 0;
   localparam int unsigned ENT_RW = 1;
   localparam int unsigned ENT_US = 2;
   localparam int unsigned ENT_A  = 5;
   localparam int unsigned ENT_D  = 6;
   localparam int unsigned ENT_PS = 7;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_ABSENT  = 2'd1,
      FLT_WRPROT  = 2'd2,
      FLT_USRPROT = 2'd3
   } fault_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_DIR,
      ST_RD_TBL,
      ST_WB_DIR,
      ST_WB_TBL,
      ST_RESP
   } walk_st_e;

endpackage

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
   import pgwalk_pkg::*;
(
   input  logic [2:0] dir_fl,
   input  logic [2:0] leaf_fl,
   input  logic       acc_wr,
   input  logic       acc_user,
   output fault_e     code
);

   logic absent;
   logic usr_deny;
   logic wr_deny;

   always_comb begin
      absent   = !(dir_fl[ENT_P] && leaf_fl[ENT_P]);
      usr_deny = acc_user && !(dir_fl[ENT_US] && leaf_fl[ENT_US]);
      wr_deny  = acc_wr && !(dir_fl[ENT_RW] && leaf_fl[ENT_RW]);
      if (absent)        code = FLT_ABSENT;
      else if (usr_deny) code = FLT_USRPROT;
      else if (wr_deny)  code = FLT_WRPROT;
      else               code = FLT_NONE;
   end

endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
   parameter int unsigned DIR_BITS      = 10,
   parameter int unsigned TBL_BITS      = 10,
   parameter int unsigned OFF_BITS      = 12,
   parameter bit          LARGE_SUPPORT = 1'b1,
   localparam int unsigned AW           = DIR_BITS + TBL_BITS + OFF_BITS,
   localparam int unsigned FRAME_W      = AW - OFF_BITS
) (
   input  logic [FRAME_W-1:0] base_frame,
   input  logic [AW-1:0]      va,
   input  logic [FRAME_W-1:0] dir_frame,
   input  logic               dir_ps,
   input  logic               large_en,
   input  logic [FRAME_W-1:0] leaf_frame,
   output logic [AW-1:0]      dir_addr,
   output logic [AW-1:0]      tbl_addr,
   output logic [AW-1:0]      pa_small,
   output logic [AW-1:0]      pa_large,
   output logic               large_hit
);

   assign dir_addr = {base_frame, va[AW-1 -: DIR_BITS], 2'b00};
   assign tbl_addr = {dir_frame, va[OFF_BITS+TBL_BITS-1 -: TBL_BITS], 2'b00};
   assign pa_small = {leaf_frame, va[OFF_BITS-1:0]};

   generate
      if (LARGE_SUPPORT) begin : g_large
         assign large_hit = large_en & dir_ps;
         assign pa_large  = {dir_frame[FRAME_W-1 -: DIR_BITS],
                             va[TBL_BITS+OFF_BITS-1:0]};
      end else begin : g_small_only
         assign large_hit = 1'b0;
         assign pa_large  = pa_small;
      end
   endgenerate

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
   import pgwalk_pkg::*;
#(
   parameter int unsigned DIR_BITS      = 10,
   parameter int unsigned TBL_BITS      = 10,
   parameter int unsigned OFF_BITS      = 12,
   parameter bit          LARGE_SUPPORT = 1'b1,
   localparam int unsigned AW           = DIR_BITS + TBL_BITS + OFF_BITS,
   localparam int unsigned FRAME_W      = AW - OFF_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FRAME_W-1:0] ptbase_frame,
   input  logic               large_pg_en,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [AW-1:0]      req_va,
   input  logic               req_wr,
   input  logic               req_user,
   output logic               rsp_valid,
   output logic               rsp_fault,
   output logic [1:0]         rsp_code,
   output logic               rsp_level,
   output logic [AW-1:0]      rsp_pa,
   output logic               mem_req,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [AW-1:0]      mem_wdata,
   input  logic               mem_ack,
   input  logic [AW-1:0]      mem_rdata
);

   localparam logic [AW-1:0] A_MASK = AW'(1) << ENT_A;
   localparam logic [AW-1:0] D_MASK = AW'(1) << ENT_D;

   generate
      if (AW != 32) begin : g_bad_width
         $error("pgwalk_top: address split must total 32 bits");
      end
      if (DIR_BITS != OFF_BITS - 2 || TBL_BITS != OFF_BITS - 2) begin : g_bad_split
         $error("pgwalk_top: each table level must fill exactly one page");
      end
   endgenerate

   walk_st_e       state;
   logic [AW-1:0]  va_q;
   logic           wr_q;
   logic           user_q;
   logic           large_q;
   logic [AW-1:0]  pde_q;
   logic [AW-1:0]  pte_q;
   fault_e         code_q;
   logic           level_q;

   logic [AW-1:0]  dir_sel;
   logic [2:0]     leaf_fl;
   fault_e         perm_code;
   logic [AW-1:0]  dir_addr;
   logic [AW-1:0]  tbl_addr;
   logic [AW-1:0]  pa_small;
   logic [AW-1:0]  pa_large;
   logic           large_hit;

   function automatic logic wb_need(input logic [AW-1:0] ent, input logic fin,
                                    input logic wr);
      return !ent[ENT_A] || (fin && wr && !ent[ENT_D]);
   endfunction

   assign dir_sel = (state == ST_RD_DIR) ? mem_rdata : pde_q;
   assign leaf_fl = (state == ST_RD_TBL) ? mem_rdata[2:0] : 3'b111;

   pgwalk_perm i_perm (
      .dir_fl   (dir_sel[2:0]),
      .leaf_fl  (leaf_fl),
      .acc_wr   (wr_q),
      .acc_user (user_q),
      .code     (perm_code)
   );

   pgwalk_addr #(
      .DIR_BITS      (DIR_BITS),
      .TBL_BITS      (TBL_BITS),
      .OFF_BITS      (OFF_BITS),
      .LARGE_SUPPORT (LARGE_SUPPORT)
   ) i_addr (
      .base_frame (ptbase_frame),
      .va         (va_q),
      .dir_frame  (dir_sel[AW-1:OFF_BITS]),
      .dir_ps     (dir_sel[ENT_PS]),
      .large_en   (large_pg_en),
      .leaf_frame (pte_q[AW-1:OFF_BITS]),
      .dir_addr   (dir_addr),
      .tbl_addr   (tbl_addr),
      .pa_small   (pa_small),
      .pa_large   (pa_large),
      .large_hit  (large_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         va_q    <= '0;
         wr_q    <= 1'b0;
         user_q  <= 1'b0;
         large_q <= 1'b0;
         pde_q   <= '0;
         pte_q   <= '0;
         code_q  <= FLT_NONE;
         level_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (req_valid) begin
               va_q    <= req_va;
               wr_q    <= req_wr;
               user_q  <= req_user;
               large_q <= 1'b0;
               code_q  <= FLT_NONE;
               level_q <= 1'b0;
               state   <= ST_RD_DIR;
            end
            ST_RD_DIR: if (mem_ack) begin
               pde_q <= mem_rdata;
               if (!mem_rdata[ENT_P]) begin
                  code_q <= FLT_ABSENT;
                  state  <= ST_RESP;
               end else if (large_hit) begin
                  large_q <= 1'b1;
                  code_q  <= perm_code;
                  if (perm_code == FLT_NONE && wb_need(mem_rdata, 1'b1, wr_q))
                     state <= ST_WB_DIR;
                  else
                     state <= ST_RESP;
               end else begin
                  state <= ST_RD_TBL;
               end
            end
            ST_RD_TBL: if (mem_ack) begin
               pte_q   <= mem_rdata;
               code_q  <= perm_code;
               level_q <= 1'b1;
               if (perm_code != FLT_NONE)           state <= ST_RESP;
               else if (!pde_q[ENT_A])              state <= ST_WB_DIR;
               else if (wb_need(mem_rdata, 1'b1, wr_q)) state <= ST_WB_TBL;
               else                                 state <= ST_RESP;
            end
            ST_WB_DIR: if (mem_ack) begin
               if (!large_q && wb_need(pte_q, 1'b1, wr_q)) state <= ST_WB_TBL;
               else                                       state <= ST_RESP;
            end
            ST_WB_TBL: if (mem_ack) state <= ST_RESP;
            ST_RESP:   state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state)
         ST_RD_DIR: begin mem_req = 1'b1; mem_addr = dir_addr; end
         ST_RD_TBL: begin mem_req = 1'b1; mem_addr = tbl_addr; end
         ST_WB_DIR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dir_addr;
            mem_wdata = pde_q | A_MASK | ((large_q && wr_q) ? D_MASK : '0);
         end
         ST_WB_TBL: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = tbl_addr;
            mem_wdata = pte_q | A_MASK | (wr_q ? D_MASK : '0);
         end
         default: ;
      endcase
   end

   assign req_ready = (state == ST_IDLE);
   assign rsp_valid = (state == ST_RESP);
   assign rsp_fault = rsp_valid && (code_q != FLT_NONE);
   assign rsp_code  = rsp_valid ? code_q : FLT_NONE;
   assign rsp_level = rsp_valid && level_q;
   assign rsp_pa    = (rsp_valid && code_q == FLT_NONE) ?
                      (large_q ? pa_large : pa_small) : '0;

   AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R1

   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready)); // R1

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R2

   AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_pa == '0 && rsp_code != 2'd0)); // R12

   AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[ENT_A]); // R9

   AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req); // R1

endmodule

// File: tb/test_pgwalk_top.sv
module test_pgwalk_top;

   typedef struct {
      logic        fault;
      logic [1:0]  code;
      logic        level;
      logic [31:0] pa;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] ptbase_frame = 20'h00100;
   logic        large_pg_en = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic        req_wr = 1'b0;
   logic        req_user = 1'b0;
   logic        rsp_valid, rsp_fault, rsp_level;
   logic [1:0]  rsp_code;
   logic [31:0] rsp_pa;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   logic [31:0] mem [bit [31:0]];
   logic [31:0] rd_log[$];
   logic [31:0] wr_log[$];
   exp_t        exp_q[$];

   always #5 clk = ~clk;

   pgwalk_top i_pgwalk_top (
      .clk(clk), .rst_n(rst_n), .ptbase_frame(ptbase_frame),
      .large_pg_en(large_pg_en), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .req_wr(req_wr), .req_user(req_user),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
      .rsp_level(rsp_level), .rsp_pa(rsp_pa), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   function automatic logic [31:0] rdw(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic chk(input logic ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // memory model: one wait cycle, ack for one cycle
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (rst_n && mem_req) begin
         mem_ack <= 1'b1;
         if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_log.push_back(mem_addr);
         end else begin
            mem_rdata <= rdw(mem_addr);
            rd_log.push_back(mem_addr);
         end
      end
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R1", "unexpected response", 32'h1, 32'h0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(rsp_fault == e.fault, e.tag, "fault flag", 32'(rsp_fault), 32'(e.fault));
            chk(rsp_code == e.code, e.tag, "code", 32'(rsp_code), 32'(e.code));
            if (e.fault)
               chk(rsp_level == e.level, e.tag, "level", 32'(rsp_level), 32'(e.level));
            chk(rsp_pa == e.pa, e.tag, "pa", rsp_pa, e.pa);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         chk(1'b0, "R1", "watchdog expired", 32'(cyc), 32'd50000);
         summary();
      end
   end

   task automatic walk(input logic [31:0] va, input logic wr, input logic user,
                       input logic fault, input logic [1:0] code, input logic level,
                       input logic [31:0] pa, input string tag);
      exp_t e;
      e.fault = fault; e.code = code; e.level = level; e.pa = pa; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_wr = wr; req_user = user;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R1", "busy after accept", 32'(req_ready), 32'h0);
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "ready after response", 32'(req_ready), 32'h1);
   endtask

   initial begin
      int r0, w0;
      // page tables: directory at 0x0010_0000
      mem[32'h0010_0004] = 32'h0020_0007;
      mem[32'h0020_000C] = 32'h0ABC_DE07;
      mem[32'h0010_000C] = 32'h0030_0007;
      mem[32'h0010_0010] = 32'h0040_0007;
      mem[32'h0040_0000] = 32'h0123_4005;
      mem[32'h0010_0014] = 32'h0050_0005;
      mem[32'h0050_0000] = 32'h0123_5007;
      mem[32'h0010_0018] = 32'h0060_0003;
      mem[32'h0060_0000] = 32'h0123_6007;
      mem[32'h0060_0004] = 32'h0123_7005;
      mem[32'h0010_0020] = 32'h0C00_0087;
      mem[32'h0C00_0048] = 32'h0D00_0067;
      mem[32'h0010_0024] = 32'h0C40_0083;

      repeat (3) @(negedge clk);
      chk(req_ready == 1'b0 || req_ready == 1'b1, "R1", "ready known in reset", 32'(req_ready), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'h1);
      chk(rsp_valid == 1'b0 && mem_req == 1'b0, "R1", "reset quiet",
          32'({rsp_valid, mem_req}), 32'h0);

      // R3 R9 R11: first 4 KB walk, accessed flags clear, spare bits set
      r0 = rd_log.size(); w0 = wr_log.size();
      walk(32'h0040_3123, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 32'h0ABC_D123, "R3");
      chk(rd_log.size() - r0 == 2, "R3", "read count", 32'(rd_log.size() - r0), 32'd2);
      chk(rd_log[r0] == 32'h0010_0004, "R2", "directory address", rd_log[r0], 32'h0010_0004);
      chk(rd_log[r0+1] == 32'h0020_000C, "R3", "table address", rd_log[r0+1], 32'h0020_000C);
      chk(wr_log.size() - w0 == 2 && wr_log[w0] == 32'h0010_0004, "R9", "dir written first",
          wr_log[w0], 32'h0010_0004);
      chk(rdw(32'h0010_0004) == 32'h0020_0027, "R9", "dir accessed", rdw(32'h0010_0004), 32'h0020_0027);
      chk(rdw(32'h0020_000C) == 32'h0ABC_DE27, "R11", "table accessed, spare kept",
          rdw(32'h0020_000C), 32'h0ABC_DE27);

      // R9: repeat with flags already set: no writes
      w0 = wr_log.size();
      walk(32'h0040_3FFF, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0ABC_DFFF, "R9");
      chk(wr_log.size() == w0, "R9", "no write-back", 32'(wr_log.size() - w0), 32'd0);

      // R10: write adds dirty to table entry only
      w0 = wr_log.size();
      walk(32'h0040_3004, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 32'h0ABC_D004, "R10");
      chk(wr_log.size() - w0 == 1, "R10", "single write", 32'(wr_log.size() - w0), 32'd1);
      chk(rdw(32'h0020_000C) == 32'h0ABC_DE67, "R10", "table dirty", rdw(32'h0020_000C), 32'h0ABC_DE67);
      chk(rdw(32'h0010_0004) == 32'h0020_0027, "R10", "dir not dirty", rdw(32'h0010_0004), 32'h0020_0027);

      // R6: absent at each level, no writes
      w0 = wr_log.size();
      walk(32'h0080_0000, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0, "R6");
      walk(32'h00C0_0000, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 32'h0, "R6");
      chk(wr_log.size() == w0, "R6", "no writes on fault", 32'(wr_log.size() - w0), 32'd0);
      chk(rdw(32'h0010_000C) == 32'h0030_0007, "R6", "dir untouched", rdw(32'h0010_000C), 32'h0030_0007);

      // R8: read-only in table entry, then in directory entry
      walk(32'h0100_0000, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 32'h0, "R8");
      walk(32'h0140_0010, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1, 32'h0, "R8");
      w0 = wr_log.size();
      walk(32'h0140_0010, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0123_5010, "R8");
      chk(wr_log.size() - w0 == 2 && wr_log[w0+1] == 32'h0050_0000, "R9", "table written second",
          wr_log[w0+1], 32'h0050_0000);

      // R7: supervisor-only directory entry
      walk(32'h0180_0000, 1'b0, 1'b1, 1'b1, 2'd3, 1'b1, 32'h0, "R7");
      walk(32'h0180_1000, 1'b1, 1'b1, 1'b1, 2'd3, 1'b1, 32'h0, "R7");
      walk(32'h0180_0ABC, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0123_6ABC, "R7");

      // R4 R10: large page write
      large_pg_en = 1'b1;
      r0 = rd_log.size();
      walk(32'h0201_2345, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 32'h0C01_2345, "R4");
      chk(rd_log.size() - r0 == 1, "R4", "one read", 32'(rd_log.size() - r0), 32'd1);
      chk(rdw(32'h0010_0020) == 32'h0C00_00E7, "R10", "large entry dirty",
          rdw(32'h0010_0020), 32'h0C00_00E7);
      walk(32'h0240_0000, 1'b0, 1'b1, 1'b1, 2'd3, 1'b0, 32'h0, "R7");

      // R5: size flag ignored when disabled
      large_pg_en = 1'b0;
      r0 = rd_log.size();
      walk(32'h0201_2345, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0D00_0345, "R5");
      chk(rd_log.size() - r0 == 2, "R5", "two reads", 32'(rd_log.size() - r0), 32'd2);
      chk(rd_log[r0+1] == 32'h0C00_0048, "R5", "table address", rd_log[r0+1], 32'h0C00_0048);

      // R12 is covered by every fault response above (pa zero, flag matches code)
      summary();
   end

endmodule